// File: doc/BRIEF.md
# Dual Controller Port Access Block

This block gives a host two 8-bit parallel controller ports behind a small byte-wide register bus. Each port has a data register and a direction register. A value written to a port's data register is stored ANDed with that port's direction register as it stands at the time of the write, so only the bits marked as outputs can be set. The stored values drive the port outputs.

A mode register selects, for each port, whether the host drives it directly or a manager owns it. In direct mode, a read of port 1 returns a handshake response picked by a 2-bit phase. The phase comes from bits 6:5 of the stored port 1 value. When the manager owns port 1, a read returns the raw byte last written to it. Reads of port 2 data always return all ones.

A latch-enable register holds two enable bits. When a write sets either bit and the pad bit of the interrupt mask input is clear, the block raises a one-cycle pad interrupt request.

Top module: `cport_direct`

## Requirements
- R1: After reset every register holds 0. Both ports are manager-controlled, `port1_o`, `port2_o`, `direct_o` and `latch_en_o` are 0, `pad_irq_o` is low, and a port 1 data read returns 0x00.
- R2: A write to address 0 (port 1 data) sets `port1_o` to the written byte ANDed with the port 1 direction register. The result appears in the cycle after the write.
- R3: A write to address 1 (port 2 data) sets `port2_o` to the written byte ANDed with the port 2 direction register.
- R4: A write to address 4 (mode) sets `direct_o[0]` from bit 0 and `direct_o[1]` from bit 1, where 1 means direct host control. Address 4 reads back {6'b0, mode}.
- R5: While `direct_o[0]` is 1, a read of address 0 returns a value chosen by bits 6:5 of the stored port 1 value. Phase 0 returns 0x90, phases 1 and 2 return 0x9F, and phase 3 returns 0x94.
- R6: While `direct_o[0]` is 0, a read of address 0 returns the unmasked byte last written to address 0.
- R7: A read of address 1 returns 0xFF in every mode, whatever has been written there.
- R8: A write to address 5 (latch enable) sets `latch_en_o` from bits 1:0. Address 5 reads back {6'b0, latch enable}.
- R9: `pad_irq_o` is high for exactly the one cycle after a write to address 5 whose bit 0 or bit 1 is set, and only if `irq_mask_i[PAD_MASK_BIT]` (bit 8 by default) is 0 at that write. At all other times it is low.
- R10: Addresses 2 and 3 hold the port 1 and port 2 direction registers and read them back. Changing a direction register does not alter a port value that is already stored.
- R11: A read of address 6 or 7 returns 0, and a write there changes no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_mask_i | input | MASK_W | Interrupt mask; bit PAD_MASK_BIT blocks the pad request |
| pad_irq_o | output | 1 | One-cycle pad interrupt request |
| port1_o | output | 8 | Stored port 1 value |
| port2_o | output | 8 | Stored port 2 value |
| direct_o | output | 2 | Per-port direct-mode flags |
| latch_en_o | output | 2 | Per-port external latch enables |

## Verification
The assertions check the following on every cycle:
- port 2 always reads back all ones;
- a direct-mode port 1 read is always one of the three handshake codes;
- a freshly written port 1 value never has a bit set outside the direction mask in force at the write;
- port 1 holds its value between writes;
- the mode flags follow their write;
- each pad request has a qualifying write as its cause, and each qualifying write produces a request.

Only the bench scenarios can show the rest:
- which handshake code belongs to each phase, including the case where masking itself sets the phase;
- that the manager-mode read returns the unmasked byte;
- that the mask bit, a zero latch value and the other mask bits act as specified;
- that unmapped addresses are inert.

// File: rtl/cport_pkg.sv
package cport_pkg;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int NPORT = 2;

  localparam logic [AW-1:0] A_P1    = 3'd0;
  localparam logic [AW-1:0] A_P2    = 3'd1;
  localparam logic [AW-1:0] A_DIR1  = 3'd2;
  localparam logic [AW-1:0] A_DIR2  = 3'd3;
  localparam logic [AW-1:0] A_MODE  = 3'd4;
  localparam logic [AW-1:0] A_LATCH = 3'd5;

  localparam int DATA_BASE = 0;
  localparam int DIR_BASE  = 2;

  localparam logic [DW-1:0] HS_PH0   = 8'h90;
  localparam logic [DW-1:0] HS_PH3   = 8'h94;
  localparam logic [DW-1:0] HS_MID   = 8'h9F;
  localparam logic [DW-1:0] P2_RD    = 8'hFF;

  localparam int PH_LO = 5;
  localparam int PH_W  = 2;

  function automatic logic [DW-1:0] hs_code(input logic [PH_W-1:0] ph);
    case (ph)
      2'd0:    hs_code = HS_PH0;
      2'd3:    hs_code = HS_PH3;
      default: hs_code = HS_MID;
    endcase
  endfunction
endpackage

// File: rtl/cport_port.sv
module cport_port
  import cport_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          data_we_i,
  input  logic          dir_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] dir_o
);
  logic [DW-1:0] data_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (dir_we_i)  dir_q  <= wdata_i;
      // mask uses direction in force at the write
      if (data_we_i) data_q <= wdata_i & dir_q;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/cport_ctrl.sv
module cport_ctrl
  import cport_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic             latch_we_i,
  input  logic             p1_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pad_masked_i,
  output logic [NPORT-1:0] mode_o,
  output logic [NPORT-1:0] latch_o,
  output logic [DW-1:0]    raw1_o,
  output logic             irq_o
);
  logic [NPORT-1:0] mode_q, latch_q;
  logic [DW-1:0]    raw1_q;
  logic             irq_q;
  logic             irq_d;

  assign irq_d = latch_we_i && (|wdata_i[NPORT-1:0]) && !pad_masked_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      latch_q <= '0;
      raw1_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (mode_we_i)  mode_q  <= wdata_i[NPORT-1:0];
      if (latch_we_i) latch_q <= wdata_i[NPORT-1:0];
      if (p1_we_i)    raw1_q  <= wdata_i;
      irq_q <= irq_d;
    end
  end

  assign mode_o  = mode_q;
  assign latch_o = latch_q;
  assign raw1_o  = raw1_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/cport_rdmux.sv
module cport_rdmux
  import cport_pkg::*;
(
  input  logic [AW-1:0]    addr_i,
  input  logic [NPORT-1:0] mode_i,
  input  logic [NPORT-1:0] latch_i,
  input  logic [DW-1:0]    raw1_i,
  input  logic [PH_W-1:0]  phase1_i,
  input  logic [DW-1:0]    dir1_i,
  input  logic [DW-1:0]    dir2_i,
  output logic [DW-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_P1:    rdata_o = mode_i[0] ? hs_code(phase1_i) : raw1_i;
      A_P2:    rdata_o = P2_RD;
      A_DIR1:  rdata_o = dir1_i;
      A_DIR2:  rdata_o = dir2_i;
      A_MODE:  rdata_o = {{(DW-NPORT){1'b0}}, mode_i};
      A_LATCH: rdata_o = {{(DW-NPORT){1'b0}}, latch_i};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cport_direct.sv
module cport_direct
  import cport_pkg::*;
#(
  parameter int MASK_W       = 16,
  parameter int PAD_MASK_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [MASK_W-1:0] irq_mask_i,
  output logic              pad_irq_o,
  output logic [DW-1:0]     port1_o,
  output logic [DW-1:0]     port2_o,
  output logic [NPORT-1:0]  direct_o,
  output logic [NPORT-1:0]  latch_en_o
);
  logic [NPORT-1:0][DW-1:0] pdata_q;
  logic [NPORT-1:0][DW-1:0] dir_q;
  logic [NPORT-1:0]         data_we, dir_we;
  logic [DW-1:0]            raw1;
  logic                     unused_mask;

  assign unused_mask = ^irq_mask_i;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign data_we[i] = wr_en_i && (addr_i == AW'(DATA_BASE + i));
    assign dir_we[i]  = wr_en_i && (addr_i == AW'(DIR_BASE + i));

    cport_port u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .data_we_i (data_we[i]),
      .dir_we_i  (dir_we[i]),
      .wdata_i   (wdata_i),
      .data_o    (pdata_q[i]),
      .dir_o     (dir_q[i])
    );
  end

  cport_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_we_i    (wr_en_i && (addr_i == A_MODE)),
    .latch_we_i   (wr_en_i && (addr_i == A_LATCH)),
    .p1_we_i      (data_we[0]),
    .wdata_i      (wdata_i),
    .pad_masked_i (irq_mask_i[PAD_MASK_BIT]),
    .mode_o       (direct_o),
    .latch_o      (latch_en_o),
    .raw1_o       (raw1),
    .irq_o        (pad_irq_o)
  );

  cport_rdmux u_rd (
    .addr_i   (addr_i),
    .mode_i   (direct_o),
    .latch_i  (latch_en_o),
    .raw1_i   (raw1),
    .phase1_i (pdata_q[0][PH_LO +: PH_W]),
    .dir1_i   (dir_q[0]),
    .dir2_i   (dir_q[1]),
    .rdata_o  (rdata_o)
  );

  assign port1_o = pdata_q[0];
  assign port2_o = pdata_q[1];
endmodule

// File: rtl/cport_direct_chk.sv
module cport_direct_chk
  import cport_pkg::*;
#(
  parameter int MASK_W       = 16,
  parameter int PAD_MASK_BIT = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [MASK_W-1:0] irq_mask_i,
  input logic              pad_irq_o,
  input logic [DW-1:0]     port1_o,
  input logic [NPORT-1:0]  direct_o,
  input logic [DW-1:0]     dir1_i
);
  logic irq_cause;
  assign irq_cause = wr_en_i && (addr_i == A_LATCH) && (|wdata_i[NPORT-1:0])
                     && !irq_mask_i[PAD_MASK_BIT];

  p_p2_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_P2) |-> (rdata_o == P2_RD));

  p_hs_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_o[0] && addr_i == A_P1) |->
      (rdata_o == HS_PH0 || rdata_o == HS_PH3 || rdata_o == HS_MID));

  p_masked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_P1) |=> ((port1_o & ~$past(dir1_i)) == '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_P1) |=> $stable(port1_o));

  p_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MODE) |=> (direct_o == $past(wdata_i[NPORT-1:0])));

  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_irq_o |-> $past(irq_cause));

  p_irq_fire_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cause |=> pad_irq_o);
endmodule

bind cport_direct cport_direct_chk #(
  .MASK_W       (MASK_W),
  .PAD_MASK_BIT (PAD_MASK_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_mask_i (irq_mask_i),
  .pad_irq_o  (pad_irq_o),
  .port1_o    (port1_o),
  .direct_o   (direct_o),
  .dir1_i     (dir_q[0])
);

// File: tb/cport_direct_tb_top.sv
module cport_direct_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MASK_W = 16;
  localparam int PADB = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [MASK_W-1:0] irq_mask_i = '0;
  logic [7:0] rdata_o, port1_o, port2_o;
  logic pad_irq_o;
  logic [1:0] direct_o, latch_en_o;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;

  // behavioural reference state
  int m_dir1, m_dir2, m_p1, m_p2, m_raw, m_mode, m_latch, m_irq;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cport_direct #(.MASK_W(MASK_W), .PAD_MASK_BIT(PADB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_mask_i(irq_mask_i),
    .pad_irq_o(pad_irq_o), .port1_o(port1_o), .port2_o(port2_o),
    .direct_o(direct_o), .latch_en_o(latch_en_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dir1 <= 0; m_dir2 <= 0; m_p1 <= 0; m_p2 <= 0;
      m_raw <= 0; m_mode <= 0; m_latch <= 0; m_irq <= 0;
    end else begin
      m_irq <= 0;
      if (wr_en_i) begin
        case (addr_i)
          3'd0: begin m_p1 <= wdata_i & m_dir1; m_raw <= wdata_i; end
          3'd1: m_p2 <= wdata_i & m_dir2;
          3'd2: m_dir1 <= wdata_i;
          3'd3: m_dir2 <= wdata_i;
          3'd4: m_mode <= wdata_i % 4;
          3'd5: begin
            m_latch <= wdata_i % 4;
            if ((wdata_i % 4) != 0 && irq_mask_i[PADB] == 1'b0) m_irq <= 1;
          end
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd(input int a);
    int ph;
    case (a)
      0: begin
        if (m_mode % 2 == 1) begin
          ph = (m_p1 / 32) % 4;
          if (ph == 0) return 8'h90;
          if (ph == 3) return 8'h94;
          return 8'h9F;
        end
        return m_raw;
      end
      1: return 8'hFF;
      2: return m_dir1;
      3: return m_dir2;
      4: return m_mode;
      5: return m_latch;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rst_ni) begin
        check(port1_o == m_p1[7:0], "R2", port1_o, m_p1);
        check(port2_o == m_p2[7:0], "R3", port2_o, m_p2);
        check(direct_o == m_mode[1:0], "R4", direct_o, m_mode);
        check(latch_en_o == m_latch[1:0], "R8", latch_en_o, m_latch);
        check(pad_irq_o == m_irq[0], "R9", pad_irq_o, m_irq);
        check(rdata_o == 8'(exp_rd(addr_i)),
              addr_i == 0 ? (m_mode % 2 == 1 ? "R5" : "R6") :
              addr_i == 1 ? "R7" : addr_i > 5 ? "R11" : "R10",
              rdata_o, exp_rd(addr_i));
        if (pad_irq_o) irq_seen++;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string req);
    @(negedge clk_i);
    addr_i = a;
    #1;
    check(rdata_o == e, req, rdata_o, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(port1_o == 8'h00 && port2_o == 8'h00, "R1", {port1_o, port2_o}, 0);
    check(direct_o == 2'b00 && latch_en_o == 2'b00 && !pad_irq_o, "R1",
          {direct_o, latch_en_o, pad_irq_o}, 0);
    rd_chk(3'd0, 8'h00, "R1");
    rd_chk(3'd4, 8'h00, "R1");
    rd_chk(3'd1, 8'hFF, "R7");

    // R2/R6 manager mode
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h5A);
    check(port1_o == 8'h5A, "R2", port1_o, 8'h5A);
    rd_chk(3'd0, 8'h5A, "R6");
    // R10 direction change leaves stored value
    wr(3'd2, 8'h0F);
    check(port1_o == 8'h5A, "R10", port1_o, 8'h5A);
    rd_chk(3'd2, 8'h0F, "R10");
    wr(3'd0, 8'hF3);
    check(port1_o == 8'h03, "R2", port1_o, 8'h03);
    rd_chk(3'd0, 8'hF3, "R6");

    // R4/R5 direct mode phases
    wr(3'd4, 8'h01);
    check(direct_o == 2'b01, "R4", direct_o, 2'b01);
    rd_chk(3'd0, 8'h90, "R5");
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h20); rd_chk(3'd0, 8'h9F, "R5");
    wr(3'd0, 8'h40); rd_chk(3'd0, 8'h9F, "R5");
    wr(3'd0, 8'h60); rd_chk(3'd0, 8'h94, "R5");
    wr(3'd0, 8'h7F); rd_chk(3'd0, 8'h94, "R5");
    wr(3'd2, 8'h9F);
    wr(3'd0, 8'hFF); rd_chk(3'd0, 8'h90, "R5");
    wr(3'd4, 8'h02);
    check(direct_o == 2'b10, "R4", direct_o, 2'b10);
    rd_chk(3'd0, 8'hFF, "R6");
    rd_chk(3'd1, 8'hFF, "R7");

    // R3 port 2
    wr(3'd3, 8'h0F);
    wr(3'd1, 8'hAB);
    check(port2_o == 8'h0B, "R3", port2_o, 8'h0B);
    rd_chk(3'd1, 8'hFF, "R7");
    rd_chk(3'd3, 8'h0F, "R10");

    // R8/R9 latch and pad request
    irq_seen = 0;
    irq_mask_i = 16'h0100;
    wr(3'd5, 8'h03);
    check(latch_en_o == 2'b11, "R8", latch_en_o, 2'b11);
    rd_chk(3'd5, 8'h03, "R8");
    irq_mask_i = 16'h00FF;
    wr(3'd5, 8'h02);
    wr(3'd5, 8'hFC);
    wr(3'd5, 8'h01);
    wr(3'd5, 8'h01);
    irq_mask_i = 16'hFEFF;
    wr(3'd5, 8'h01);
    @(negedge clk_i);
    check(irq_seen == 4, "R9", irq_seen, 4);

    // R11 unmapped addresses
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    rd_chk(3'd6, 8'h00, "R11");
    rd_chk(3'd7, 8'h00, "R11");
    check(port1_o == 8'h9F && port2_o == 8'h0B, "R11", {port1_o, port2_o}, 16'h9F0B);

    // mixed traffic against the model
    for (int i = 0; i < 300; i++) begin
      irq_mask_i = (i % 3 == 0) ? 16'h0100 : 16'h0000;
      wr(3'((i * 5) % 8), 8'((i * 37 + 11) % 256));
      rd_chk(3'(i % 8), 8'(exp_rd(i % 8)), "R5");
    end

    repeat (2) @(negedge clk_i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule